// File: doc/BRIEF.md
# Zero-Default Word Memory on an APB Completer Port

This block is a no-wait-state APB completer that holds a window of 32-bit words. A master writes a word in the usual two-cycle transfer: a setup cycle with select high and enable low, then an access cycle with enable high. The word is stored on the clock edge that ends the access cycle. Reads use the same two-cycle transfer, and the read data is valid throughout both the setup and the access cycle.

Each word has a valid flag next to it. A word that has not been written since the last reset reads as zero, whatever the storage array holds. An asynchronous active-low reset clears every flag at once, so the whole memory returns to zero in a single step without walking the array. An address outside the window, or one that is not word aligned, is never stored, and a read of such an address returns zero.

Top module: `apb_zero_mem`

## Requirements
- R1: A write is committed only when an access cycle (sel=1, enable=1) directly follows a setup cycle (sel=1, enable=0). An enable-high cycle with no setup cycle before it stores nothing.
- R2: A write transfer with write=1 stores wdata into the word indexed by addr[11:2] on the clock edge that ends the access cycle. A later write to the same word replaces the earlier value.
- R3: A word that has not been written since the last reset reads as 0.
- R4: rdata combinationally shows the addressed word while sel is high, so it is already valid in the setup cycle and in the access cycle, with no wait state.
- R5: While rst_n is low, rdata is 0. Once reset is released, every word reads 0 until it is written again. Reset is asynchronous and also takes effect between clock edges.
- R6: An address with any of bits [31:12] or bits [1:0] set is outside the window. A write to it changes no word, and a read of it returns 0.
- R7: When a read setup directly follows a write access to the same word, the read returns the value just written, in both of its cycles.
- R8: While sel is low, rdata is 0.
- R9: A transfer with write=0 leaves every stored word unchanged, even when wdata carries other data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| sel | input | 1 | Completer select |
| enable | input | 1 | Access-phase marker (low in setup, high in access) |
| write | input | 1 | 1 = write transfer, 0 = read transfer |
| addr | input | 32 | Byte address; word index in bits [11:2] |
| wdata | input | 32 | Write data, taken at the end of the access cycle |
| rdata | output | 32 | Read data; 0 when not selected, out of window or unwritten |

## Verification
A read result appears in the same cycle its address and select are driven, with no clock edge in between. The bench therefore samples rdata 1 ns after it changes the inputs on the falling edge, in both the setup and the access cycle. A write becomes visible one edge later, at the rising edge that closes its access cycle. Every check that depends on a write is made in a later cycle, and the back-to-back case samples at the first possible point: the setup cycle right after that edge. The asynchronous reset is checked between clock edges, so no rising edge can mask a reset that acts only on the clock.

// File: rtl/apb_zm_pkg.sv
package apb_zm_pkg;

   // transfer-phase tracker state held by the decoder
   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_SETUP = 1'b1
   } phase_e;

   // number of byte-offset bits below the word index
   function automatic int lane_bits(input int data_w);
      return $clog2(data_w / 8);
   endfunction

endpackage

// File: rtl/apb_zm_decode.sv
module apb_zm_decode
   import apb_zm_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WIN_BITS = 12,
   parameter int LSB_W    = 2,
   localparam int IDX_W   = WIN_BITS - LSB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              enable,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              addr_ok,
   output logic              wr_commit
);

   phase_e phase_q;
   logic   hi_ok;
   logic   lo_ok;

   // the phase register remembers that the previous cycle was a setup cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               phase_q <= PH_IDLE;
      else if (sel && !enable)  phase_q <= PH_SETUP;
      else                      phase_q <= PH_IDLE;
   end

   generate
      if (ADDR_W > WIN_BITS) begin : g_hi_check
         assign hi_ok = (addr[ADDR_W-1:WIN_BITS] == '0);
      end else begin : g_hi_none
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign lo_ok     = (addr[LSB_W-1:0] == '0);
   assign addr_ok   = hi_ok & lo_ok;
   assign idx       = addr[WIN_BITS-1:LSB_W];
   assign wr_commit = sel & enable & write & addr_ok & (phase_q == PH_SETUP);

   AST_COMMIT_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(sel && !enable)); // R1

endmodule

// File: rtl/apb_zm_store.sv
module apb_zm_store #(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 10,
   localparam int DEPTH  = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  valid_q;

   // contents carry no reset; the valid flags decide what a read may see
   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  valid_q      <= '0;
      else if (we) valid_q[idx] <= 1'b1;
   end

   assign rdata  = mem[idx];
   assign rvalid = valid_q[idx];

   AST_RESET_EMPTY: assert property (@(posedge clk)
      !rst_n |-> (valid_q == '0)); // R5

   AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> valid_q[$past(idx)]); // R2

endmodule

// File: rtl/apb_zero_mem.sv
module apb_zero_mem #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int WIN_BITS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              enable,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int LSB_W = apb_zm_pkg::lane_bits(DATA_W);
   localparam int IDX_W = WIN_BITS - LSB_W;

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("apb_zero_mem: DATA_W must be a multiple of 8 and at least 16");
      end
      if (WIN_BITS <= LSB_W) begin : g_bad_win
         $error("apb_zero_mem: WIN_BITS must exceed the byte-lane bits");
      end
      if (ADDR_W < WIN_BITS) begin : g_bad_addr
         $error("apb_zero_mem: ADDR_W must cover the window");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              addr_ok;
   logic              wr_commit;
   logic [DATA_W-1:0] mem_rdata;
   logic              mem_rvalid;

   apb_zm_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_BITS (WIN_BITS),
      .LSB_W    (LSB_W)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .enable    (enable),
      .write     (write),
      .addr      (addr),
      .idx       (idx),
      .addr_ok   (addr_ok),
      .wr_commit (wr_commit)
   );

   apb_zm_store #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_commit),
      .idx    (idx),
      .wdata  (wdata),
      .rdata  (mem_rdata),
      .rvalid (mem_rvalid)
   );

   assign rdata = (sel && addr_ok && mem_rvalid) ? mem_rdata : '0;

   AST_MISALIGNED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[LSB_W-1:0] != '0) |-> !wr_commit); // R6

   AST_UNWRITTEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !mem_rvalid) |-> (rdata == '0)); // R3

   AST_FRESH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit ##1 (sel && !write && addr == $past(addr)) |-> (rdata == $past(wdata))); // R7

   AST_READ_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !write |-> !wr_commit); // R9

endmodule

// File: tb/sim_apb_zero_mem.sv
module sim_apb_zero_mem;

   localparam int NW = 1024;

   logic        clk    = 1'b0;
   logic        rst_n  = 1'b1;
   logic        sel    = 1'b0;
   logic        enable = 1'b0;
   logic        write  = 1'b0;
   logic [31:0] addr   = '0;
   logic [31:0] wdata  = '0;
   logic [31:0] rdata;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   apb_zero_mem u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .enable (enable),
      .write  (write),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata)
   );

   function automatic logic [31:0] pat(input int i);
      return (32'(i) * 32'h0100_0193) ^ 32'hA5C3_0000;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; enable = 1'b0; write = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      enable = 1'b1;
   endtask

   task automatic do_read(input logic [31:0] a, output logic [31:0] s, output logic [31:0] v);
      @(negedge clk);
      sel = 1'b1; enable = 1'b0; write = 1'b0; addr = a; wdata = 32'hDEAD_BEEF;
      #1 s = rdata;
      @(negedge clk);
      enable = 1'b1;
      #1 v = rdata;
   endtask

   task automatic go_idle();
      @(negedge clk);
      sel = 1'b0; enable = 1'b0; write = 1'b0;
   endtask

   initial begin
      logic [31:0] s, v;
      #2 rst_n = 1'b0;
      sel = 1'b1; addr = 32'h0;
      #3 chk("R5 rdata during reset", rdata, 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      go_idle();

      // R3: fresh memory reads zero everywhere
      for (int i = 0; i < NW; i++) begin
         do_read(32'(i) << 2, s, v);
         chk("R3 unwritten word", v, 32'h0);
      end

      // R2: fill even words, back to back
      for (int i = 0; i < NW; i += 2) do_write(32'(i) << 2, pat(i));
      go_idle();
      for (int i = 0; i < NW; i++) begin
         do_read(32'(i) << 2, s, v);
         chk("R2/R3 sweep", v, (i % 2 == 0) ? pat(i) : 32'h0);
      end

      // R6: out-of-window and misaligned writes and reads
      do_write(32'h0000_1008, 32'h1111_1111);
      do_write(32'h0000_0009, 32'h2222_2222);
      go_idle();
      do_read(32'h0000_0008, s, v);
      chk("R6 word 2 untouched", v, pat(2));
      do_read(32'h0000_1008, s, v);
      chk("R6 read above window", v, 32'h0);
      do_read(32'h0000_000A, s, v);
      chk("R6 misaligned read", v, 32'h0);
      do_read(32'h0000_000C, s, v);
      chk("R6 word 3 untouched", v, 32'h0);

      // R1: an access cycle with no setup before it stores nothing
      go_idle();
      @(negedge clk);
      sel = 1'b1; enable = 1'b1; write = 1'b1; addr = 32'h0000_000C; wdata = 32'h3333_3333;
      go_idle();
      do_read(32'h0000_000C, s, v);
      chk("R1 no setup no store", v, 32'h0);

      // R9: reads leave storage unchanged
      do_read(32'h0000_0010, s, v);
      chk("R9 first read", v, pat(4));
      do_read(32'h0000_0010, s, v);
      chk("R9 repeat read", v, pat(4));

      // R7/R4: read setup right after a write access
      do_write(32'h0000_0014, 32'hCAFE_0005);
      do_read(32'h0000_0014, s, v);
      chk("R4 setup-cycle data", s, 32'hCAFE_0005);
      chk("R7 access-cycle data", v, 32'hCAFE_0005);
      do_write(32'h0000_0018, 32'h0000_600D);
      do_read(32'h0000_0018, s, v);
      chk("R2 overwrite", v, 32'h0000_600D);

      // R8: deselected port outputs zero
      go_idle();
      addr = 32'h0000_0010;
      #1 chk("R8 idle rdata", rdata, 32'h0);

      // R5: asynchronous reset between edges
      @(negedge clk);
      sel = 1'b1; enable = 1'b0; write = 1'b0; addr = 32'h0000_0010;
      #1 chk("R5 pre-reset value", rdata, pat(4));
      #3 rst_n = 1'b0;
      #1 chk("R5 async clear", rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      go_idle();
      do_read(32'h0000_0010, s, v);
      chk("R5 word 4 after reset", v, 32'h0);
      do_read(32'h0000_0014, s, v);
      chk("R5 word 5 after reset", v, 32'h0);
      go_idle();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog (all R) got=timeout exp=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule